// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives the command and address pins for a single DRAM bank. Each request carries a read/write flag, a row and a column. The block remembers whether a row is open and which row it is. It then issues the shortest legal command sequence for the request:

- a column command alone when the request hits the open row;
- an activate followed by the column command when the bank is closed;
- precharge, then activate, then the column command when the request names a different row.

The activate-to-column, precharge-to-activate and column-to-data delays are parameters, counted in controller clocks.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. The block lowers `req_ready` in two cases: while it is waiting out a precharge or activate delay, and for the first seven clocks after any column command. This keeps column commands at least one burst apart, so data bursts never collide.

Row and column share one address field. The row travels with the activate command and the column with the read or write command. Each column command moves an 8-beat burst, so the three lowest column bits are sent as zero. The block announces each burst on `rd_valid_o` for a read and on `wr_due_o` for a write. The announcement starts the CAS latency after the column command and lasts eight cycles.

Top module: `bank_cmd_seq`

## Requirements
- R1: While reset is asserted and immediately after it, `cmd_o` is NOP, `req_ready` is high, `row_open_o` is low, and both burst strobes are low.
- R2: A request to a closed bank drives ACT (with the full row on `cmd_addr_o`) in the cycle after acceptance. The RD or WR command follows exactly T_RCD cycles after the ACT.
- R3: A request whose row equals the open row drives RD or WR in the cycle after acceptance, with no ACT or PRE.
- R4: A request to a row other than the open one drives PRE in the cycle after acceptance, ACT T_RP cycles after the PRE, and RD or WR T_RCD cycles after that ACT.
- R5: On RD and WR, `cmd_addr_o` carries the column with its three least significant bits forced to zero and all other bits zero above the column width. On ACT it carries the row.
- R6: `rd_valid_o` (read) or `wr_due_o` (write) is high for exactly 8 consecutive cycles, starting T_CL cycles after the column command. The two strobes are never high together, and back-to-back bursts join without a gap.
- R7: `req_ready` is low throughout a PRE or ACT wait and for the 7 cycles after a column command. Column commands are therefore at least 8 cycles apart, and a request held while `req_ready` is low is not taken.
- R8: At most one command is driven per cycle, and every cycle without a command drives NOP. The encoding of `cmd_o` is NOP=0, ACT=1, RD=2, WR=3, PRE=4.
- R9: `row_open_o` rises with each ACT and falls with each PRE. While a row is open, `open_row_o` equals the row that was sent with the last ACT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Bank-local row |
| req_col | input | COL_W | Bank-local column |
| cmd_o | output | 3 | Command code (NOP/ACT/RD/WR/PRE) |
| cmd_addr_o | output | ADDR_W | Shared row/column address field |
| rd_valid_o | output | 1 | Read burst beat due on the data bus |
| wr_due_o | output | 1 | Write burst beat must be driven |
| row_open_o | output | 1 | A row is open in the bank |
| open_row_o | output | ROW_W | Currently open row |

## Verification
The bound checker watches every cycle for the following:

- that a column command only appears with a row open and at least T_RCD cycles after the last ACT;
- that every ACT is at least T_RP cycles after the last PRE;
- that column addresses have their low three bits clear and the two strobes are exclusive;
- that the tracked open row matches the address sent with ACT;
- that `req_ready` stays low during waits and right after column commands.

Only the bench scenarios show the exact cycle positions of each command in hit, closed and miss sequences. They also show the length and start of the data window, the seamless joining of back-to-back bursts, and the loss of the open row on a mid-run reset.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ACT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bank_delay_ctr.sv
module bank_delay_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             pre,
  input  logic [ROW_W-1:0] act_row,
  output logic             open,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open <= 1'b0;
      row  <= '0;
    end else if (act) begin
      open <= 1'b1;
      row  <= act_row;
    end else if (pre) begin
      open <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_data_window.sv
// Delays each column command by T_CL and then holds a strobe for one burst.
// A single pending slot suffices while T_CL <= BURST, because column commands
// are spaced a full burst apart.
module bank_data_window #(
  parameter int T_CL  = 5,
  parameter int BURST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic rd_valid,
  output logic wr_due
);
  localparam int DW = $clog2(T_CL + 1);
  localparam int BW = (BURST > 2) ? $clog2(BURST) : 1;

  logic          pend, pend_wr, fire;
  logic [DW-1:0] dly;
  logic          active, active_wr;
  logic [BW-1:0] beats;

  assign fire = pend && (dly == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      pend_wr <= 1'b0;
      dly     <= '0;
    end else if (start) begin
      pend    <= 1'b1;
      pend_wr <= start_wr;
      dly     <= DW'(T_CL - 1);
    end else if (fire) begin
      pend    <= 1'b0;
    end else if (pend) begin
      dly     <= dly - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      active_wr <= 1'b0;
      beats     <= '0;
    end else if (fire) begin
      active    <= 1'b1;
      active_wr <= pend_wr;
      beats     <= BW'(BURST - 1);
    end else if (active) begin
      if (beats == '0) active <= 1'b0;
      else             beats  <= beats - 1'b1;
    end
  end

  assign rd_valid = active && !active_wr;
  assign wr_due   = active &&  active_wr;
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bank_seq_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int COL_W  = 10,
  parameter int BURST  = 8,
  parameter int T_RCD  = 4,
  parameter int T_CL   = 5,
  parameter int T_RP   = 3,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              rd_valid_o,
  output logic              wr_due_o,
  output logic              row_open_o,
  output logic [ROW_W-1:0]  open_row_o
);
  localparam int MAXT = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int GW   = (BURST > 2) ? $clog2(BURST) : 1;

  seq_state_e        state, nxt_state;
  cmd_e              cmd_q, nxt_cmd;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic              pend_wr, col_wr;
  logic [ROW_W-1:0]  pend_row;
  logic [COL_W-1:0]  pend_col;
  logic              accept, hit, tmr_zero, gap_zero;
  logic              tmr_load, col_fire;
  logic [TW-1:0]     tmr_val;

  function automatic logic [ADDR_W-1:0] col_field(input logic [COL_W-1:0] c);
    return ADDR_W'(c) & ~ADDR_W'(BURST - 1);
  endfunction

  assign req_ready = (state == ST_IDLE) && gap_zero;
  assign accept    = req_valid && req_ready;
  assign hit       = row_open_o && (open_row_o == req_row);

  always_comb begin
    nxt_state = state;
    nxt_cmd   = CMD_NOP;
    nxt_addr  = '0;
    col_wr    = pend_wr;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (hit) begin
          nxt_cmd  = req_write ? CMD_WR : CMD_RD;
          nxt_addr = col_field(req_col);
          col_wr   = req_write;
        end else if (row_open_o) begin
          nxt_cmd   = CMD_PRE;
          nxt_state = ST_PRE;
        end else begin
          nxt_cmd   = CMD_ACT;
          nxt_addr  = ADDR_W'(req_row);
          nxt_state = ST_ACT;
        end
      end
      ST_PRE: if (tmr_zero) begin
        nxt_cmd   = CMD_ACT;
        nxt_addr  = ADDR_W'(pend_row);
        nxt_state = ST_ACT;
      end
      ST_ACT: if (tmr_zero) begin
        nxt_cmd   = pend_wr ? CMD_WR : CMD_RD;
        nxt_addr  = col_field(pend_col);
        nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  assign col_fire = (nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR);
  assign tmr_load = (nxt_cmd == CMD_PRE) || (nxt_cmd == CMD_ACT);
  assign tmr_val  = (nxt_cmd == CMD_PRE) ? TW'(T_RP - 1) : TW'(T_RCD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      pend_wr  <= 1'b0;
      pend_row <= '0;
      pend_col <= '0;
    end else begin
      state  <= nxt_state;
      cmd_q  <= nxt_cmd;
      addr_q <= nxt_addr;
      if (accept) begin
        pend_wr  <= req_write;
        pend_row <= req_row;
        pend_col <= req_col;
      end
    end
  end

  assign cmd_o      = cmd_q;
  assign cmd_addr_o = addr_q;

  bank_delay_ctr #(.W(TW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  bank_delay_ctr #(.W(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(col_fire), .load_val(GW'(BURST - 1)), .zero(gap_zero)
  );

  bank_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .act(nxt_cmd == CMD_ACT), .pre(nxt_cmd == CMD_PRE),
    .act_row(nxt_addr[ROW_W-1:0]),
    .open(row_open_o), .row(open_row_o)
  );

  bank_data_window #(.T_CL(T_CL), .BURST(BURST)) u_data (
    .clk(clk), .rst_n(rst_n), .start(col_fire), .start_wr(col_wr),
    .rd_valid(rd_valid_o), .wr_due(wr_due_o)
  );
endmodule

// File: rtl/bank_cmd_seq_chk.sv
module bank_cmd_seq_chk
  import bank_seq_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int ADDR_W = 16,
  parameter int BURST  = 8,
  parameter int T_RCD  = 4,
  parameter int T_RP   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [2:0]        cmd_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic              rd_valid_o,
  input logic              wr_due_o,
  input logic              row_open_o,
  input logic [ROW_W-1:0]  open_row_o
);
  localparam int LIM   = ((T_RCD > T_RP) ? T_RCD : T_RP) + 1;
  localparam int CW    = $clog2(LIM + 1);
  localparam int LOW_W = (BURST > 2) ? $clog2(BURST) : 1;

  logic [CW-1:0] since_act, since_pre;
  logic          is_col;

  assign is_col = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '0;
      since_pre <= CW'(LIM);
    end else begin
      if (cmd_o == CMD_ACT)          since_act <= CW'(1);
      else if (since_act < CW'(LIM)) since_act <= since_act + 1'b1;
      if (cmd_o == CMD_PRE)          since_pre <= CW'(1);
      else if (since_pre < CW'(LIM)) since_pre <= since_pre + 1'b1;
    end
  end

  p_col_row_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> row_open_o);
  p_col_after_rcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_act >= CW'(T_RCD)));
  p_act_after_rp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT) |-> (since_pre >= CW'(T_RP)));
  p_col_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (cmd_addr_o[LOW_W-1:0] == '0));
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid_o && wr_due_o));
  p_wait_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == CMD_PRE) || (cmd_o == CMD_ACT) || is_col) |-> !req_ready);
  p_cmd_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o <= 3'd4);
  p_act_tracks_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT) |-> (row_open_o && open_row_o == cmd_addr_o[ROW_W-1:0]));
  p_pre_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE) |-> !row_open_o);
endmodule

bind bank_cmd_seq bank_cmd_seq_chk #(
  .ROW_W(ROW_W), .ADDR_W(ADDR_W), .BURST(BURST), .T_RCD(T_RCD), .T_RP(T_RP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_o(cmd_o),
  .cmd_addr_o(cmd_addr_o), .rd_valid_o(rd_valid_o), .wr_due_o(wr_due_o),
  .row_open_o(row_open_o), .open_row_o(open_row_o)
);

// File: tb/bank_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module bank_cmd_seq_tb_top;
  localparam int T_RCD = 4;
  localparam int T_CL  = 5;
  localparam int T_RP  = 3;
  localparam int BURST = 8;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4;

  typedef struct packed {
    logic        wr;
    logic [15:0] row;
    logic [9:0]  col;
    logic [1:0]  kind;   // 0 hit, 1 closed bank, 2 row miss
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 16'h1234, 10'h3FF, 2'd1},
    '{1'b1, 16'h1234, 10'h00F, 2'd0},
    '{1'b0, 16'h1234, 10'h007, 2'd0},
    '{1'b1, 16'hFFFF, 10'h155, 2'd2},
    '{1'b0, 16'hFFFF, 10'h2AA, 2'd0},
    '{1'b0, 16'h0000, 10'h001, 2'd2},
    '{1'b1, 16'h0000, 10'h3FF, 2'd0},
    '{1'b0, 16'h8001, 10'h010, 2'd2}
  };

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_ready, rd_valid_o, wr_due_o, row_open_o;
  logic [2:0]  cmd_o;
  logic [15:0] cmd_addr_o, open_row_o;
  int          n_checks = 0, n_fails = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  bank_cmd_seq #(.T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .BURST(BURST)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .cmd_o(cmd_o),
    .cmd_addr_o(cmd_addr_o), .rd_valid_o(rd_valid_o), .wr_due_o(wr_due_o),
    .row_open_o(row_open_o), .open_row_o(open_row_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(cmd_o == C_NOP && req_ready && !row_open_o && !rd_valid_o && !wr_due_o, req,
          "idle state {cmd,ready,open,rd,wr}",
          {cmd_o, req_ready, row_open_o, rd_valid_o, wr_due_o}, {C_NOP, 4'b1000});
  endtask

  task automatic send(input vec_t v);
    int          coln;
    bit          seq_ok = 1, addr_ok = 1, rdy_ok = 1, stb_ok = 1;
    logic [2:0]  bad_a = '0, bad_e = '0, e;
    logic [15:0] bad_addr = '0, bad_addr_e = '0;
    logic [15:0] colx = {6'h0, v.col & 10'h3F8};
    string       rq = (v.kind == 2'd0) ? "R3" : (v.kind == 2'd1) ? "R2" : "R4";
    coln = (v.kind == 2'd0) ? 0 : (v.kind == 2'd1) ? T_RCD : T_RP + T_RCD;
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_row = v.row; req_col = v.col;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    for (int n = 0; n <= coln; n++) begin
      @(negedge clk);
      if (n == 0) req_valid = 0;
      e = C_NOP;
      if (n == coln)                           e = v.wr ? C_WR : C_RD;
      else if (v.kind == 2'd1 && n == 0)       e = C_ACT;
      else if (v.kind == 2'd2 && n == 0)       e = C_PRE;
      else if (v.kind == 2'd2 && n == T_RP)    e = C_ACT;
      if (cmd_o != e && seq_ok) begin seq_ok = 0; bad_a = cmd_o; bad_e = e; end
      if (e == C_ACT && cmd_addr_o != v.row && addr_ok) begin
        addr_ok = 0; bad_addr = cmd_addr_o; bad_addr_e = v.row;
      end
      if (n == coln && cmd_addr_o != colx && addr_ok) begin
        addr_ok = 0; bad_addr = cmd_addr_o; bad_addr_e = colx;
      end
      if (req_ready) rdy_ok = 0;
    end
    check(seq_ok, rq, "command sequence (R8 NOP between)", bad_a, bad_e);
    check(addr_ok, "R5", "address field", bad_addr, bad_addr_e);
    for (int m = 1; m <= T_CL + BURST; m++) begin
      @(negedge clk);
      if ((v.wr ? wr_due_o : rd_valid_o) != (m >= T_CL && m < T_CL + BURST)) stb_ok = 0;
      if (v.wr ? rd_valid_o : wr_due_o) stb_ok = 0;
      if (req_ready != (m >= BURST - 1)) rdy_ok = 0;
    end
    check(stb_ok, "R6", "burst strobe window", stb_ok, 1);
    check(rdy_ok, "R7", "ready during waits and column spacing", rdy_ok, 1);
    check(row_open_o && open_row_o == v.row, "R9", "open row status",
          {row_open_o, open_row_o}, {1'b1, v.row});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");            // during reset
    rst_n = 1;
    @(negedge clk);
    check_idle("R1");            // after release

    foreach (VECS[i]) send(VECS[i]);

    // Back-to-back hits: column commands 8 apart, strobe continuous (R6, R7)
    begin
      int c0 = -1, c1 = -1, hi = 0, first = -1, last = -1;
      @(negedge clk);
      req_valid = 1; req_write = 0; req_row = 16'h8001; req_col = 10'h020;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      for (int n = 0; n < 30; n++) begin
        @(negedge clk);
        if (n == 0) req_col = 10'h040;
        if (cmd_o == C_RD) begin
          if (c0 < 0) c0 = n;
          else begin c1 = n; req_valid = 0; end
        end
        if (rd_valid_o) begin
          hi++; if (first < 0) first = n; last = n;
        end
      end
      check(c0 == 0 && c1 == 8, "R7", "column command spacing", c1 - c0, 8);
      check(hi == 16 && first == T_CL && last == T_CL + 15, "R6",
            "joined burst length", hi, 16);
    end

    // Held request while busy is not taken early (R7): miss then watch ready
    begin
      bit early = 0;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_row = 16'h0042; req_col = 10'h0;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      for (int n = 0; n < T_RP + T_RCD; n++) begin
        @(negedge clk);
        if (cmd_o == C_WR) early = 1;
      end
      @(negedge clk);
      req_valid = 0;
      check(!early && cmd_o == C_WR && cmd_addr_o == 16'h0, "R7",
            "held request issued only after waits", cmd_o, C_WR);
    end

    // Mid-run reset clears open row (R1, R9), next request needs ACT (R2)
    repeat (16) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check_idle("R1");
    rst_n = 1;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_row = 16'h0042; req_col = 10'h008;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(cmd_o == C_ACT && cmd_addr_o == 16'h0042, "R2",
          "ACT after reset loses open row", cmd_o, C_ACT);
    repeat (T_RCD) @(negedge clk);
    check(cmd_o == C_RD && cmd_addr_o == 16'h0008, "R2",
          "RD T_RCD after ACT", cmd_o, C_RD);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule